// File: doc/BRIEF.md
# Coarse-Fine Code Combiner for a Two-Stage Converter

This block joins the result of a two-stage successive-approximation converter. The first stage delivers a 5-bit coarse code and the second delivers a 6-bit fine code for the same sample. The two codes overlap by one redundant bit, so the second stage can absorb errors that the first stage made near a decision threshold. The fine result of a sample arrives one sample after its coarse result, because the second stage converts sample n while the first stage is already taking sample n+1. The combiner holds each coarse code until its matching fine code arrives. It then forms one 10-bit word using only addition, subtraction and compare, and registers that word.

The merged value is the coarse code times 32, plus the fine code, minus 32, which is half the fine range. The coarse code is capped at 30, so its all-ones value is never used. The result is bounded at zero from below and at the 10-bit maximum from above. A fine code that arrives with no held coarse code is discarded.

Top module: `cfc_combiner`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, out_vld is 0 and out_word is 0. No coarse code is held, so a fine code as the first input after reset gives no output.
- R2: For a matched pair, out_word equals coarse*32 + fine - 32.
- R3: A coarse code of 5'b11111 (31) is merged as if it were 30.
- R4: When coarse*32 + fine is below 32, out_word is 0.
- R5: out_vld is high for exactly one cycle, in the cycle after the clock edge that samples a fine_vld pulse that has a held coarse code.
- R6: A fine code with no held coarse code is dropped: out_vld stays 0 and out_word keeps its value.
- R7: When coarse_vld and fine_vld are high in the same cycle, the fine code pairs with the coarse code held before that cycle. The new coarse code is held for the next fine code.
- R8: Each held coarse code is used by at most one fine code. A second fine code with no new coarse code in between is dropped.
- R9: out_word keeps its last value in every cycle where out_vld is 0.
- R10: out_word never exceeds 991 (30*32 + 63 - 32), so the 10-bit result never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coarse_code | input | 5 | First-stage code |
| coarse_vld | input | 1 | Qualifies coarse_code for one cycle |
| fine_code | input | 6 | Second-stage code |
| fine_vld | input | 1 | Qualifies fine_code for one cycle |
| out_word | output | 10 | Merged result |
| out_vld | output | 1 | One-cycle pulse marking a new out_word |

## Verification
The merge is tried with isolated coarse/fine pairs that land on chosen points:
- mid-range, to confirm the weighting and the offset;
- a result of exactly zero and a result below zero, which separate a wrong offset from missing lower saturation;
- coarse 31 against coarse 30, which shows whether the cap is present;
- the largest legal pair, which catches a wrap.

Overlapped traffic sends a coarse and a fine code in the same cycle, and a run of back-to-back samples does this every cycle. A mismatch in either shows a coarse code that was not delayed, or a hold register that was overwritten before use. Orphan fine codes, sent after reset and after a hold register has already been used, show whether a stale coarse code is reused and whether the output word is left untouched.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CFC_CW = 5;
  localparam int CFC_FW = 6;
endpackage

// File: rtl/cfc_align.sv
module cfc_align #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_code,
  input  logic          coarse_vld,
  input  logic          take,
  output logic          held,
  output logic [CW-1:0] held_code
);
  localparam int CMAX = (1 << CW) - 2;

  logic          held_d;
  logic [CW-1:0] code_d;
  logic          code_en;

  always_comb begin
    code_en = coarse_vld;
    code_d  = (coarse_code > CW'(CMAX)) ? CW'(CMAX) : coarse_code;
    if (coarse_vld)
      held_d = 1'b1;
    else if (take)
      held_d = 1'b0;
    else
      held_d = held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_code <= '0;
    end else begin
      held <= held_d;
      if (code_en)
        held_code <= code_d;
    end
  end
endmodule

// File: rtl/cfc_merge.sv
module cfc_merge #(
  parameter int CW = 5,
  parameter int FW = 6
) (
  input  logic [CW-1:0]    coarse,
  input  logic [FW-1:0]    fine,
  output logic [CW+FW-2:0] word
);
  localparam int OW   = CW + FW - 1;
  localparam int SW   = CW + FW;
  localparam int OFS  = 1 << (FW - 1);
  localparam int OMAX = (1 << OW) - 1;

  logic [SW-1:0] total;
  logic [SW-1:0] diff;

  always_comb begin
    total = ({{FW{1'b0}}, coarse} << (FW - 1)) + {{CW{1'b0}}, fine};
    diff  = total - SW'(OFS);
    if (total < SW'(OFS))
      word = '0;
    else if (diff > SW'(OMAX))
      word = OW'(OMAX);
    else
      word = diff[OW-1:0];
  end
endmodule

// File: rtl/cfc_outreg.sv
module cfc_outreg #(
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [OW-1:0] word_d,
  output logic [OW-1:0] word_q,
  output logic          vld_q
);
  logic vld_d;

  always_comb vld_d = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load)
        word_q <= word_d;
    end
  end
endmodule

// File: rtl/cfc_combiner.sv
module cfc_combiner
  import cfc_pkg::*;
#(
  parameter int CW = CFC_CW,
  parameter int FW = CFC_FW,
  parameter int OW = CW + FW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_code,
  input  logic          coarse_vld,
  input  logic [FW-1:0] fine_code,
  input  logic          fine_vld,
  output logic [OW-1:0] out_word,
  output logic          out_vld
);
  logic          held;
  logic [CW-1:0] held_code;
  logic [OW-1:0] merged;
  logic          load;

  always_comb load = fine_vld & held;

  cfc_align #(.CW(CW)) u_align (
    .clk(clk), .rst_n(rst_n), .coarse_code(coarse_code),
    .coarse_vld(coarse_vld), .take(fine_vld),
    .held(held), .held_code(held_code)
  );

  cfc_merge #(.CW(CW), .FW(FW)) u_merge (
    .coarse(held_code), .fine(fine_code), .word(merged)
  );

  cfc_outreg #(.OW(OW)) u_outreg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .word_d(merged), .word_q(out_word), .vld_q(out_vld)
  );
endmodule

// File: rtl/cfc_combiner_chk.sv
module cfc_combiner_chk #(
  parameter int CW = 5,
  parameter int FW = 6,
  parameter int OW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coarse_vld,
  input logic          fine_vld,
  input logic          held,
  input logic [OW-1:0] out_word,
  input logic          out_vld
);
  localparam int TOP = ((1 << CW) - 2) * (1 << (FW - 1)) + (1 << FW) - 1 - (1 << (FW - 1));

  assert_vld_needs_fine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(fine_vld));

  assert_matched_gives_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_vld && held) |=> out_vld);

  assert_orphan_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_vld && !held) |=> !out_vld);

  assert_single_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_vld && !coarse_vld) |=> !held);

  assert_word_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_word));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_word <= OW'(TOP));
endmodule

bind cfc_combiner cfc_combiner_chk #(.CW(CW), .FW(FW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .coarse_vld(coarse_vld), .fine_vld(fine_vld),
  .held(held), .out_word(out_word), .out_vld(out_vld)
);

// File: tb/test_cfc_combiner.sv
module test_cfc_combiner;
  logic       clk;
  logic       rst_n;
  logic [4:0] coarse_code;
  logic       coarse_vld;
  logic [5:0] fine_code;
  logic       fine_vld;
  logic [9:0] out_word;
  logic       out_vld;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  cfc_combiner i_cfc_combiner (
    .clk(clk), .rst_n(rst_n), .coarse_code(coarse_code), .coarse_vld(coarse_vld),
    .fine_code(fine_code), .fine_vld(fine_vld), .out_word(out_word), .out_vld(out_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int expect_word(int c, int f);
    int cc = (c == 31) ? 30 : c;
    int v  = cc * 32 + f - 32;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs applied at negedge, held for one rising edge, outputs sampled at next negedge
  task automatic step(int c, bit cv, int f, bit fv);
    coarse_code = 5'(c); coarse_vld = cv; fine_code = 6'(f); fine_vld = fv;
    @(posedge clk);
    @(negedge clk);
    coarse_vld = 1'b0; fine_vld = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; coarse_code = '0; coarse_vld = 0; fine_code = '0; fine_vld = 0;
    repeat (3) @(negedge clk);
    check("R1 vld in reset", out_vld, 0);
    check("R1 word in reset", out_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld after release", out_vld, 0);
    check("R1 word after release", out_word, 0);
    step(0, 0, 50, 1);
    check("R1 R6 orphan after reset vld", out_vld, 0);
    check("R1 R6 orphan after reset word", out_word, 0);
  endtask

  task automatic t_pair(string req, int c, int f);
    step(c, 1, 0, 0);
    check({req, " no vld on coarse"}, out_vld, 0);
    step(0, 0, f, 1);
    check({req, " vld"}, out_vld, 1);
    check({req, " word"}, out_word, expect_word(c, f));
    step(0, 0, 0, 0);
    check("R5 single-cycle vld", out_vld, 0);
    check("R9 word held", out_word, expect_word(c, f));
  endtask

  task automatic t_overlap;
    step(5, 1, 0, 0);
    step(7, 1, 10, 1);
    check("R7 overlap vld", out_vld, 1);
    check("R7 overlap uses older coarse", out_word, expect_word(5, 10));
    step(0, 0, 33, 1);
    check("R7 newer coarse kept", out_word, expect_word(7, 33));
    step(0, 0, 20, 1);
    check("R8 reuse dropped vld", out_vld, 0);
    check("R8 reuse word unchanged", out_word, expect_word(7, 33));
  endtask

  task automatic t_stream;
    int prev = 3;
    step(prev, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      int c = (i * 7 + 2) % 32;
      int f = (i * 13 + 5) % 64;
      step(c, 1, f, 1);
      check("R7 stream vld", out_vld, 1);
      check("R2 stream word", out_word, expect_word(prev, f));
      prev = c;
    end
    step(0, 0, 44, 1);
    check("R7 stream tail", out_word, expect_word(prev, 44));
  endtask

  initial begin
    t_reset();
    t_pair("R2 mid", 10, 40);
    t_pair("R2 offset zero", 0, 32);
    t_pair("R4 below zero", 0, 5);
    t_pair("R3 coarse 31 capped", 31, 63);
    t_pair("R10 largest", 30, 63);
    t_pair("R2 fine zero", 16, 0);
    t_pair("R4 small coarse", 1, 0);
    t_overlap();
    t_stream();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule